// File: doc/BRIEF.md
# Gear Shift Validity Monitor

This block judges whether a requested gear change on an eight-speed gearbox may go ahead, and keeps a running tally of shift attempts. The current gear and the requested gear are both 3-bit numbers from 0 to 7. A change is allowed when the requested gear matches the current gear or sits exactly one step above or below it. The numbering does not wrap, so 0 and 7 are not neighbours. This judgement appears on a combinational output at all times.

A commit button records an attempt. The button input is synchronised inside the block, and each press creates exactly one commit event, however long the button is held. On that event, an allowed shift advances a pass counter and a refused shift advances a fail counter. A wear limit from 1 to 7 is captured while reset is held. When the fail count reaches this limit, a broken flag is raised and stays high. While the flag is high, all further commits are ignored until the next reset. A second flag shows whether the pass count has reached the constant 3.

Top module: `gearshift_monitor`

## Requirements
- R1: `shift_ok_o` is high in the same cycle whenever the requested gear equals the current gear.
- R2: `shift_ok_o` is high when the requested gear is exactly one above or one below the current gear. It is low for every pair that differs by two or more.
- R3: There is no wraparound. The pairs current 0 / requested 7 and current 7 / requested 0 give `shift_ok_o` low.
- R4: While reset is held, and after it is released, the counts, `pass_mark_o` and `broken_o` are all zero. The value on `wear_limit_i` is captured while reset is active.
- R5: One rising edge of `commit_btn_i` causes exactly one commit, for any hold length. The counts change on the third rising clock edge after the button rises.
- R6: A commit with `shift_ok_o` high adds one to `pass_count_o`. A commit with `shift_ok_o` low adds one to `fail_count_o`.
- R7: `broken_o` rises on the commit that brings `fail_count_o` equal to the captured wear limit.
- R8: Once `broken_o` is high it stays high, and later commits change neither count until reset.
- R9: `pass_count_o` saturates at 7 and does not wrap.
- R10: `pass_mark_o` is high exactly when `pass_count_o` is 3 or more.
- R11: Changing the gear inputs without a button press leaves both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cur_gear_i | input | 3 | Current gear, 0 to 7 |
| req_gear_i | input | 3 | Requested gear, 0 to 7 |
| wear_limit_i | input | 3 | Fail limit, 1 to 7; captured during reset |
| commit_btn_i | input | 1 | Commit button, asynchronous and level-held |
| shift_ok_o | output | 1 | Combinational verdict on the gear pair |
| pass_count_o | output | 3 | Committed allowed shifts, saturating |
| fail_count_o | output | 3 | Committed refused shifts |
| pass_mark_o | output | 1 | Pass count is at least 3 |
| broken_o | output | 1 | Sticky: fail count has reached the limit |

## Verification
`shift_ok_o` is combinational. The bench checks it half a cycle after the gears are driven, without waiting for any clock edge. Button and gear changes are driven on falling edges. The counts and flags are due on the third rising edge after the button rises, which covers two synchroniser stages and the edge-detect register. For the latency check in R5, the bench samples on the falling edge just before that rising edge and again just after it. All other count checks are made several cycles after the button is released, when the values have settled. `broken_o` changes on the same edge as the fail count, so it is checked at the same sample point.

// File: rtl/gearshift_pkg.sv
`timescale 1ns/1ps
package gearshift_pkg;
  localparam int GEAR_W    = 3;
  localparam int CNT_W     = 3;
  localparam int LIM_W     = 3;
  localparam int SUCC_MARK = 3;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_PASS = 2'd1,
    EV_FAIL = 2'd2
  } commit_ev_e;
endpackage

// File: rtl/gs_reset_sync.sv
`timescale 1ns/1ps
module gs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= 1'b1;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gs_press_detect.sv
`timescale 1ns/1ps
module gs_press_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic press_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= btn_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign press_o = sync_q[STAGES-1] & ~last_q;

  // R5: a single press yields a single-cycle event
  assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);
endmodule

// File: rtl/gs_adjacency.sv
`timescale 1ns/1ps
module gs_adjacency #(
  parameter int GW = 3
) (
  input  logic [GW-1:0] cur_i,
  input  logic [GW-1:0] req_i,
  output logic          ok_o
);
  localparam int EW = GW + 1;
  logic [EW-1:0] cur_x, req_x, cur_up, req_up;

  always_comb begin
    cur_x  = {1'b0, cur_i};
    req_x  = {1'b0, req_i};
    cur_up = cur_x + EW'(1);
    req_up = req_x + EW'(1);
    ok_o   = (cur_x == req_x) || (cur_up == req_x) || (req_up == cur_x);
  end
endmodule

// File: rtl/gs_wear_tracker.sv
`timescale 1ns/1ps
module gs_wear_tracker
  import gearshift_pkg::*;
#(
  parameter int CW   = 3,
  parameter int LW   = 3,
  parameter int MARK = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] limit_i,
  input  logic          commit_i,
  input  logic          ok_i,
  output logic [CW-1:0] pass_o,
  output logic [CW-1:0] fail_o,
  output logic          mark_o,
  output logic          broken_o
);
  localparam int XW = CW + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] pass_q, pass_d, fail_q, fail_d;
  logic [LW-1:0] limit_q;
  logic          brk_q, brk_d, cnt_en;
  logic [XW-1:0] fail_inc, limit_x;
  commit_ev_e    ev;

  // limit is loaded on every edge while the synchronised reset is active
  always_ff @(posedge clk) begin
    if (!rst_n) limit_q <= limit_i;
  end

  always_comb begin
    cnt_en   = commit_i & ~brk_q;
    ev       = !cnt_en ? EV_IDLE : (ok_i ? EV_PASS : EV_FAIL);
    fail_inc = {1'b0, fail_q} + XW'(1);
    limit_x  = XW'(limit_q);
    pass_d   = pass_q;
    fail_d   = fail_q;
    brk_d    = brk_q;
    case (ev)
      EV_PASS: if (pass_q != CNT_MAX) pass_d = pass_q + CW'(1);
      EV_FAIL: begin
        if (fail_q != CNT_MAX) fail_d = fail_q + CW'(1);
        if (fail_inc >= limit_x) brk_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= '0;
      fail_q <= '0;
      brk_q  <= 1'b0;
    end else if (cnt_en) begin
      pass_q <= pass_d;
      fail_q <= fail_d;
      brk_q  <= brk_d;
    end
  end

  assign pass_o   = pass_q;
  assign fail_o   = fail_q;
  assign broken_o = brk_q;
  assign mark_o   = (pass_q >= CW'(MARK));

  assert_pass_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && ok_i && !broken_o && pass_o != CNT_MAX) |=> pass_o == $past(pass_o) + CW'(1));
  assert_fail_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !ok_i && !broken_o) |=> fail_o == $past(fail_o) + CW'(1));
  assert_break_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(broken_o) |-> fail_o == CW'(limit_q));
  assert_sticky_broken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    broken_o |=> broken_o);
  assert_frozen_when_broken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    broken_o |=> ($stable(pass_o) && $stable(fail_o)));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o == CNT_MAX) |=> (pass_o == CNT_MAX));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(pass_o) && $stable(fail_o)));
endmodule

// File: rtl/gearshift_monitor.sv
`timescale 1ns/1ps
module gearshift_monitor
  import gearshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEAR_W-1:0] cur_gear_i,
  input  logic [GEAR_W-1:0] req_gear_i,
  input  logic [LIM_W-1:0]  wear_limit_i,
  input  logic              commit_btn_i,
  output logic              shift_ok_o,
  output logic [CNT_W-1:0]  pass_count_o,
  output logic [CNT_W-1:0]  fail_count_o,
  output logic              pass_mark_o,
  output logic              broken_o
);
  logic rst_sync_n;
  logic press;

  gs_reset_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  gs_press_detect #(.STAGES(SYNC_DEPTH)) u_press (
    .clk(clk), .rst_n(rst_sync_n), .btn_i(commit_btn_i), .press_o(press));

  gs_adjacency #(.GW(GEAR_W)) u_adj (
    .cur_i(cur_gear_i), .req_i(req_gear_i), .ok_o(shift_ok_o));

  gs_wear_tracker #(.CW(CNT_W), .LW(LIM_W), .MARK(SUCC_MARK)) u_wear (
    .clk(clk), .rst_n(rst_sync_n), .limit_i(wear_limit_i),
    .commit_i(press), .ok_i(shift_ok_o),
    .pass_o(pass_count_o), .fail_o(fail_count_o),
    .mark_o(pass_mark_o), .broken_o(broken_o));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cur_gear_i == '0 && req_gear_i == '1) || (cur_gear_i == '1 && req_gear_i == '0))
      |-> !shift_ok_o);
  assert_mark_tracks_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pass_count_o < CNT_W'(SUCC_MARK)) |-> !pass_mark_o);
endmodule

// File: tb/gearshift_monitor_tb.sv
`timescale 1ns/1ps
module gearshift_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cur_g, req_g, lim;
  logic       btn;
  logic       ok;
  logic [2:0] pcnt, fcnt;
  logic       mark, brk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_pass, m_fail, m_lim;
  bit m_brk;

  always #2 clk = ~clk;

  gearshift_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cur_gear_i(cur_g), .req_gear_i(req_g),
    .wear_limit_i(lim), .commit_btn_i(btn), .shift_ok_o(ok),
    .pass_count_o(pcnt), .fail_count_o(fcnt), .pass_mark_o(mark), .broken_o(brk));

  function automatic bit ref_ok(int g, int s);
    return (s == g) || (s == g + 1) || (s + 1 == g);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int limit);
    @(negedge clk);
    rst_n = 1'b0; btn = 1'b0; lim = 3'(limit);
    repeat (3) @(negedge clk);
    chk("R4 pass in reset", pcnt, 0);
    chk("R4 broken in reset", brk, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_pass = 0; m_fail = 0; m_brk = 0; m_lim = limit;
  endtask

  task automatic check_state(string tag);
    chk({tag, " R6 pass count"}, pcnt, m_pass);
    chk({tag, " R6 fail count"}, fcnt, m_fail);
    chk({tag, " R10 mark"}, mark, (m_pass >= 3) ? 1 : 0);
    chk({tag, " R7 broken"}, brk, m_brk);
  endtask

  task automatic shift(int g, int s, int hold);
    bit exp_ok;
    cur_g = 3'(g); req_g = 3'(s);
    @(negedge clk);
    exp_ok = ref_ok(g, s);
    chk((g == s) ? "R1 ok" : "R2 ok", ok, exp_ok);
    btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (4) @(negedge clk);
    if (!m_brk) begin
      if (exp_ok) begin
        if (m_pass < 7) m_pass++;
      end else begin
        m_fail++;
        if (m_fail >= m_lim) m_brk = 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; btn = 1'b0; cur_g = '0; req_g = '0; lim = 3'd7;

    do_reset(7);
    check_state("R4 after release");

    // exhaustive combinational verdict
    for (int g = 0; g < 8; g++) begin
      for (int s = 0; s < 8; s++) begin
        cur_g = 3'(g); req_g = 3'(s);
        #1;
        if ((g == 0 && s == 7) || (g == 7 && s == 0)) chk("R3 no wrap", ok, 0);
        else if (g == s) chk("R1 equal", ok, 1);
        else chk("R2 adjacency", ok, ref_ok(g, s));
      end
    end
    @(negedge clk);

    // R5 latency and single event for a long hold
    cur_g = 3'd4; req_g = 3'd5;
    @(negedge clk);
    btn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 not yet counted", pcnt, 0);
    @(negedge clk);
    chk("R5 counted on third edge", pcnt, 1);
    repeat (8) @(negedge clk);
    btn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 one event for long hold", pcnt, 1);
    m_pass = 1;

    // R11 gear activity without press
    for (int i = 0; i < 6; i++) begin
      cur_g = 3'($urandom_range(0, 7)); req_g = 3'($urandom_range(0, 7));
      @(negedge clk);
    end
    chk("R11 pass unchanged", pcnt, m_pass);
    chk("R11 fail unchanged", fcnt, m_fail);

    // R9 saturation with plenty of passes
    for (int i = 0; i < 9; i++) shift(i % 8, i % 8, 1);
    check_state("R9 saturate");
    chk("R9 pass at max", pcnt, 7);

    // R7/R8 break at limit 2, then ignored commits
    do_reset(2);
    shift(0, 7, 2);
    check_state("R7 first fail");
    shift(7, 0, 1);
    check_state("R7 reach limit");
    chk("R7 broken raised", brk, 1);
    shift(3, 3, 1);
    shift(1, 5, 1);
    chk("R8 pass frozen", pcnt, 0);
    chk("R8 fail frozen", fcnt, 2);
    chk("R8 broken sticky", brk, 1);

    // R7 limit 1
    do_reset(1);
    shift(2, 2, 1);
    shift(2, 4, 3);
    check_state("R7 limit one");

    // constrained random sessions
    for (int sess = 0; sess < 4; sess++) begin
      do_reset($urandom_range(1, 7));
      for (int k = 0; k < 25; k++) begin
        int g, s;
        g = $urandom_range(0, 7);
        if ($urandom_range(0, 2) != 0) s = (g + $urandom_range(0, 2) + 7) % 8;
        else s = $urandom_range(0, 7);
        shift(g, s, $urandom_range(1, 4));
        check_state("random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule